// File: doc/BRIEF.md
# Maskable Interrupt Controller

This block collects interrupt events from a handful of sources and turns them into one interrupt request for a processor core. The sources are a timer overflow, an external pin edge, a port-change detector, and two groups of peripheral events. Every event sets a sticky flag, whether or not it is enabled. Software clears a flag by writing it. A request reaches the core only if three conditions hold: the flag is set, its own enable is set, and the global enable is set. Peripheral flags must also pass a peripheral-group enable.

Software sees five 8-bit registers on a simple register bus. Writes are synchronous. Reads are combinational from the selected address. The core control register packs everything for the three core sources: the global enable (bit 7), the peripheral-group enable (bit 6), the enables for timer, pin and port change (bits 5, 4, 3), and their flags (bits 2, 1, 0). Each core enable at bit n+3 gates the flag at bit n.

Two further registers hold the peripheral flags, one per group, and two hold the matching enables. Group 1 implements bits 6, 3, 2, 1 and 0 (mask 0x4F). Group 2 implements bits 7 and 3 (mask 0x88). When the core takes the interrupt it pulses an acknowledge input, which clears the global enable. A return-from-interrupt pulse sets the global enable again.

Top module: `maskable_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0x00 and the request output is low.
- R2: The register addresses are: core control 0, group-1 flags 1, group-2 flags 2, group-1 enables 3, group-2 enables 4. Any other address reads 0x00. Unimplemented bits read 0 and ignore writes: group-1 registers keep only mask 0x4F and group-2 registers keep only mask 0x88.
- R3: An event pulse sets its flag on the next clock edge, whatever the state of its own enable, the group enable or the global enable.
- R4: A set flag stays set until software writes 0 to it. If an event arrives in the same cycle as a write that clears its flag, the flag ends up set.
- R5: With the global enable set, the request is high exactly when some core flag (bits 2..0) is set together with its enable (bits 5..3).
- R6: A peripheral flag that is set together with its enable raises the request only while the group enable (bit 6) is set.
- R7: With the global enable (bit 7) clear, the request is low whatever the flags and the other enables.
- R8: An acknowledge pulse clears the global enable at the next edge. A return pulse sets it. Acknowledge wins over a return or a register write in the same cycle.
- R9: Events on unimplemented peripheral bit positions set nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_tmr | input | 1 | Timer overflow event pulse |
| ev_ext | input | 1 | External pin edge event pulse |
| ev_chg | input | 1 | Port-change event pulse |
| ev_per1 | input | 8 | Group-1 peripheral event pulses, one per bit |
| ev_per2 | input | 8 | Group-2 peripheral event pulses, one per bit |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| irq_ack | input | 1 | Interrupt entry taken by the core |
| irq_ret | input | 1 | Return from interrupt |
| irq | output | 1 | Interrupt request to the core |

## Verification
Two same-cycle collisions matter here.

The first is a hardware event arriving in the same cycle as a software write that clears its flag. The bench pulses the timer event together with a write of 0x00 to the core control register, then reads the register back and expects the flag bit to be set.

The second is an acknowledge colliding with either a return pulse or a register write that sets the global enable. The bench drives both in one cycle and expects bit 7 to read as 0 and the request to stay low.

// File: rtl/mic_pkg.sv
package mic_pkg;
    localparam int DW = 8;
    localparam int AW = 3;

    // core control register bit positions (software-visible layout)
    localparam int B_GIE  = 7;
    localparam int B_PEIE = 6;
    localparam int B_EN0  = 3;   // enables occupy B_EN0 .. B_EN0+NCORE-1
    localparam int NCORE  = 3;   // flags occupy 0 .. NCORE-1

    typedef enum logic [AW-1:0] {
        A_CTRL = 3'd0,
        A_PF1  = 3'd1,
        A_PF2  = 3'd2,
        A_PE1  = 3'd3,
        A_PE2  = 3'd4
    } mic_addr_e;

    typedef struct packed {
        logic [DW-1:0] val;
    } mic_reg_t;
endpackage

// File: rtl/mic_src_reg.sv
module mic_src_reg
    import mic_pkg::*;
#(
    parameter logic [DW-1:0] IMPL   = 8'hFF,
    parameter bit            STICKY = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] set,
    output logic [DW-1:0] q
);
    mic_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr) r_d.val = wdata & IMPL;
        if (STICKY) r_d.val = r_d.val | (set & IMPL);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign q = r_q.val;
endmodule

// File: rtl/mic_core_ctrl.sv
module mic_core_ctrl
    import mic_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic [NCORE-1:0] ev_core,
    input  logic          irq_ack,
    input  logic          irq_ret,
    output logic [DW-1:0] q
);
    mic_reg_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (wr) c_d.val = wdata;
        c_d.val[NCORE-1:0] = c_d.val[NCORE-1:0] | ev_core;
        if (irq_ret) c_d.val[B_GIE] = 1'b1;
        if (irq_ack) c_d.val[B_GIE] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign q = c_q.val;
endmodule

// File: rtl/mic_req_merge.sv
module mic_req_merge
    import mic_pkg::*;
(
    input  logic [DW-1:0] ctrl,
    input  logic [DW-1:0] pf1,
    input  logic [DW-1:0] pe1,
    input  logic [DW-1:0] pf2,
    input  logic [DW-1:0] pe2,
    output logic          core_hit,
    output logic          per_hit,
    output logic          irq
);
    always_comb begin
        core_hit = |(ctrl[NCORE-1:0] & ctrl[B_EN0 +: NCORE]);
        per_hit  = (|(pf1 & pe1)) | (|(pf2 & pe2));
        irq      = ctrl[B_GIE] & (core_hit | (ctrl[B_PEIE] & per_hit));
    end
endmodule

// File: rtl/maskable_irq_ctrl.sv
module maskable_irq_ctrl
    import mic_pkg::*;
#(
    parameter logic [7:0] P1_IMPL = 8'h4F,
    parameter logic [7:0] P2_IMPL = 8'h88
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_tmr,
    input  logic       ev_ext,
    input  logic       ev_chg,
    input  logic [7:0] ev_per1,
    input  logic [7:0] ev_per2,
    input  logic       reg_wr,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       irq_ack,
    input  logic       irq_ret,
    output logic       irq
);
    localparam int NPREG = 4;   // pf1, pf2, pe1, pe2 at addresses 1..4

    logic [DW-1:0] ctrl_q;
    logic [DW-1:0] preg_q [NPREG];
    logic [DW-1:0] preg_set [NPREG];
    logic          core_hit;
    logic          per_hit;

    assign preg_set[0] = ev_per1;
    assign preg_set[1] = ev_per2;
    assign preg_set[2] = '0;
    assign preg_set[3] = '0;

    mic_core_ctrl u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr && (reg_addr == A_CTRL)),
        .wdata   (reg_wdata),
        .ev_core ({ev_tmr, ev_ext, ev_chg}),
        .irq_ack (irq_ack),
        .irq_ret (irq_ret),
        .q       (ctrl_q)
    );

    for (genvar g = 0; g < NPREG; g++) begin : g_preg
        localparam logic [DW-1:0] MASK = (g % 2 == 0) ? P1_IMPL : P2_IMPL;
        localparam bit            STK  = (g < 2);
        mic_src_reg #(.IMPL(MASK), .STICKY(STK)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (reg_wr && (reg_addr == AW'(g + 1))),
            .wdata (reg_wdata),
            .set   (preg_set[g]),
            .q     (preg_q[g])
        );
    end

    mic_req_merge u_merge (
        .ctrl     (ctrl_q),
        .pf1      (preg_q[0]),
        .pe1      (preg_q[2]),
        .pf2      (preg_q[1]),
        .pe2      (preg_q[3]),
        .core_hit (core_hit),
        .per_hit  (per_hit),
        .irq      (irq)
    );

    always_comb begin
        case (reg_addr)
            A_CTRL:  reg_rdata = ctrl_q;
            A_PF1:   reg_rdata = preg_q[0];
            A_PF2:   reg_rdata = preg_q[1];
            A_PE1:   reg_rdata = preg_q[2];
            A_PE2:   reg_rdata = preg_q[3];
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mic_checker.sv
module mic_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] ctrl_q,
    input logic       reg_wr,
    input logic [2:0] reg_addr,
    input logic       ev_tmr,
    input logic       irq_ack,
    input logic       irq_ret,
    input logic       core_hit,
    input logic       irq
);
    a_r3_tmr_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tmr |=> ctrl_q[2]);

    a_r4_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[2] && !(reg_wr && reg_addr == 3'd0)) |=> ctrl_q[2]);

    a_r8_ack_clears_gie: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !ctrl_q[7]);

    a_r8_ret_sets_gie: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ret && !irq_ack) |=> ctrl_q[7]);

    a_r7_no_req_without_gie: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[7] |-> !irq);

    a_r6_group_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ctrl_q[6]) |-> core_hit);
endmodule

bind maskable_irq_ctrl mic_checker chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_q   (ctrl_q),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .ev_tmr   (ev_tmr),
    .irq_ack  (irq_ack),
    .irq_ret  (irq_ret),
    .core_hit (core_hit),
    .irq      (irq)
);

// File: tb/maskable_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module maskable_irq_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_tmr = 0, ev_ext = 0, ev_chg = 0;
    logic [7:0] ev_per1 = '0, ev_per2 = '0;
    logic       reg_wr = 0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_ack = 0, irq_ret = 0;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    maskable_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .ev_tmr(ev_tmr), .ev_ext(ev_ext), .ev_chg(ev_chg),
        .ev_per1(ev_per1), .ev_per2(ev_per2), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_ack(irq_ack),
        .irq_ret(irq_ret), .irq(irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    // drive at a falling edge, captured at the next rising edge
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic clear_all();
        for (int a = 0; a < 5; a++) wr(3'(a), 8'h00);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check("R1 reset read", v, 8'h00);
        end
        check("R1 reset irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_regs();
        logic [7:0] v;
        wr(3'd0, 8'h38); rd(3'd0, v); check("R2 ctrl rw", v, 8'h38);
        wr(3'd1, 8'hFF); rd(3'd1, v); check("R2 pf1 mask", v, 8'h4F);
        wr(3'd2, 8'hFF); rd(3'd2, v); check("R2 pf2 mask", v, 8'h88);
        wr(3'd3, 8'hFF); rd(3'd3, v); check("R2 pe1 mask", v, 8'h4F);
        wr(3'd4, 8'hFF); rd(3'd4, v); check("R2 pe2 mask", v, 8'h88);
        wr(3'd5, 8'hFF); rd(3'd5, v); check("R2 unmapped", v, 8'h00);
        clear_all();
    endtask

    task automatic t_flags();
        logic [7:0] v;
        ev_tmr = 1; ev_ext = 1; ev_chg = 1; ev_per1 = 8'hFF; ev_per2 = 8'hFF;
        @(negedge clk);
        ev_tmr = 0; ev_ext = 0; ev_chg = 0; ev_per1 = '0; ev_per2 = '0;
        rd(3'd0, v); check("R3 core flags", v, 8'h07);
        rd(3'd1, v); check("R9 pf1 set", v, 8'h4F);
        rd(3'd2, v); check("R9 pf2 set", v, 8'h88);
        check("R7 no irq", {7'd0, irq}, 8'h00);
        repeat (3) @(negedge clk);
        rd(3'd0, v); check("R4 flags held", v, 8'h07);
        rd(3'd1, v); check("R4 pf1 held", v, 8'h4F);
        clear_all();
    endtask

    task automatic t_collide_clear();
        logic [7:0] v;
        ev_tmr = 1; wr(3'd0, 8'h00); ev_tmr = 0;
        rd(3'd0, v); check("R4 event beats clear", v, 8'h04);
        wr(3'd0, 8'h00);
        rd(3'd0, v); check("R4 cleared", v, 8'h00);
    endtask

    task automatic t_core();
        wr(3'd0, 8'hA0);
        check("R5 idle", {7'd0, irq}, 8'h00);
        ev_ext = 1; @(negedge clk); ev_ext = 0;
        check("R5 unenabled flag", {7'd0, irq}, 8'h00);
        ev_tmr = 1; @(negedge clk); ev_tmr = 0;
        check("R5 enabled flag", {7'd0, irq}, 8'h01);
        wr(3'd0, 8'hA0);
        check("R5 after clear", {7'd0, irq}, 8'h00);
        clear_all();
    endtask

    task automatic t_periph();
        wr(3'd3, 8'h02);
        ev_per1 = 8'h02; @(negedge clk); ev_per1 = '0;
        wr(3'd0, 8'h80);
        check("R6 group off", {7'd0, irq}, 8'h00);
        wr(3'd0, 8'hC0);
        check("R6 group on", {7'd0, irq}, 8'h01);
        wr(3'd0, 8'h40);
        check("R7 gie off", {7'd0, irq}, 8'h00);
        clear_all();
    endtask

    task automatic t_gie();
        logic [7:0] v;
        wr(3'd0, 8'hA0);
        ev_tmr = 1; @(negedge clk); ev_tmr = 0;
        check("R5 pending", {7'd0, irq}, 8'h01);
        irq_ack = 1; @(negedge clk); irq_ack = 0;
        rd(3'd0, v); check("R8 ack clears", v, 8'h24);
        check("R8 irq after ack", {7'd0, irq}, 8'h00);
        irq_ret = 1; @(negedge clk); irq_ret = 0;
        rd(3'd0, v); check("R8 ret sets", v, 8'hA4);
        irq_ack = 1; wr(3'd0, 8'hA4); irq_ack = 0;
        rd(3'd0, v); check("R8 ack beats write", v, 8'h24);
        irq_ack = 1; irq_ret = 1; @(negedge clk); irq_ack = 0; irq_ret = 0;
        rd(3'd0, v); check("R8 ack beats ret", v, 8'h24);
        check("R8 irq low", {7'd0, irq}, 8'h00);
        clear_all();
    endtask

    initial begin
        #800000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_flags();
        t_collide_clear();
        t_core();
        t_periph();
        t_gie();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule